// File: doc/BRIEF.md
# Shared Bus Priority Arbiter with Operand Coherency

This block decides which of four masters owns a shared system bus: an external requester, two DMA channels and the CPU. Priority is fixed with the external requester on top, the DMA channels in the middle and the CPU at the bottom. The two DMA channels are ordered against each other by a programmable arbitration ID per channel. With no requester pending, the bus parks on the CPU.

The owner keeps the bus until it reaches an operand boundary. Each master reports three flags for its own bus cycles: a cycle is running, the cycle terminates in this clock, and the terminating cycle is the last piece of its operand. A fourth flag marks a cycle inside a locked read-modify-write sequence. A long word moved through a narrow port is never split. A test-and-set sequence is never split either. Masters that mark each operand as last can be preempted between operands. Such masters include a DMA channel doing dual-address transfers, one moving data between ports of different widths, and the CPU stacking registers.

The arbiter re-evaluates priority only at an allowed boundary. The new grant is registered, so it appears on the clock after the boundary.

Top module: `sba_top`

## Requirements
- R1: After reset the grant is on the CPU: `grant` = 4'b1000 and `grant_idx` = 3. Index encoding is 0 external, 1 DMA channel 0, 2 DMA channel 1, 3 CPU, and `grant` bit i is set exactly when `grant_idx` = i.
- R2: Exactly one bit of `grant` is set in every cycle after reset.
- R3: When arbitration is allowed, the external request wins over any DMA request and over the CPU.
- R4: When arbitration is allowed and both DMA channels request, with no external request, the channel with the larger arbitration ID wins. If the IDs are equal, channel 0 wins.
- R5: When arbitration is allowed and no master requests, the grant moves to (or stays on) the CPU.
- R6: While the owner has a bus cycle running that does not end this clock, the grant does not change on the next clock.
- R7: Once the owner ends a cycle that is not the last piece of its operand, the grant stays until that operand's last piece ends. This holds through idle clocks between pieces, so a four-piece long-word transfer keeps the bus for all four pieces.
- R8: A cycle that ends with the lock flag set keeps the grant, even if that cycle is marked last. The grant can change only after a cycle ends with last set and lock clear.
- R9: When the owner ends a last piece without lock, the grant goes to the winner of the pending requests on the next clock. Two operands marked last in turn can therefore be split by a higher-priority requester.
- R10: An owner with no cycle running and no operand open can be preempted by a higher-priority request on the next clock.
- R11: The cycle flags of masters that do not own the bus have no effect on the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_req | input | 1 | External bus request |
| dma_req | input | 2 | Request per DMA channel, bit 0 is channel 0 |
| cpu_req | input | 1 | CPU request (the CPU also receives the parked grant) |
| dma_id0 | input | ID_W | Arbitration ID of DMA channel 0 |
| dma_id1 | input | ID_W | Arbitration ID of DMA channel 1 |
| cyc_run | input | 4 | Per master: a bus cycle is in progress this clock |
| cyc_done | input | 4 | Per master: the running cycle terminates this clock |
| cyc_last | input | 4 | Per master: the terminating cycle is the last piece of its operand |
| cyc_lock | input | 4 | Per master: the terminating cycle is inside a locked read-modify-write sequence |
| grant | output | 4 | One-hot bus grant |
| grant_idx | output | 2 | Index of the current owner |

## Verification
The bench offers competing requests in several arrangements: all masters together, DMA pairs with their IDs set both ways round, and requests that drop away one by one. These show that the fixed order and the ID tie-break are applied. It then runs owner traffic with a competitor waiting. The traffic shapes are a four-piece transfer with an idle gap, a multi-clock single cycle, a locked read followed by a write, and back-to-back single-piece operands. Each shape shows that the grant moves only at a true boundary and on the following clock. Stray flags from non-owners, and an owner that drops its request, complete the picture: the first must be ignored, and the second must let the grant park on the CPU.

// File: rtl/sba_pkg.sv
package sba_pkg;
    localparam int NM = 4;
    localparam int IW = 2;
    typedef logic [IW-1:0] idx_t;
    localparam idx_t IDX_EXT = 2'd0;
    localparam idx_t IDX_D0  = 2'd1;
    localparam idx_t IDX_D1  = 2'd2;
    localparam idx_t IDX_CPU = 2'd3;

    typedef struct packed {
        idx_t owner;
        logic open;
    } arb_st_t;
endpackage

// File: rtl/sba_pick.sv
module sba_pick
    import sba_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            ext_req,
    input  logic [1:0]      dma_req,
    input  logic [ID_W-1:0] id0,
    input  logic [ID_W-1:0] id1,
    output idx_t            win
);
    logic d1_first;

    always_comb begin
        d1_first = (id1 > id0);
        if (ext_req)
            win = IDX_EXT;
        else if (dma_req[0] && dma_req[1])
            win = d1_first ? IDX_D1 : IDX_D0;
        else if (dma_req[0])
            win = IDX_D0;
        else if (dma_req[1])
            win = IDX_D1;
        else
            win = IDX_CPU;
    end
endmodule

// File: rtl/sba_track.sv
module sba_track
    import sba_pkg::*;
(
    input  idx_t          owner,
    input  logic          open_q,
    input  logic [NM-1:0] cyc_run,
    input  logic [NM-1:0] cyc_done,
    input  logic [NM-1:0] cyc_last,
    input  logic [NM-1:0] cyc_lock,
    output logic          release_now,
    output logic          open_d
);
    logic run, done, last, lock, ends;

    always_comb begin
        run  = cyc_run[owner];
        done = cyc_done[owner];
        last = cyc_last[owner];
        lock = cyc_lock[owner];
        ends = run && done;
        if (run)
            release_now = ends && last && !lock;
        else
            release_now = !open_q;
        if (release_now)
            open_d = 1'b0;
        else if (ends)
            open_d = 1'b1;
        else
            open_d = open_q;
    end
endmodule

// File: rtl/sba_top.sv
module sba_top
    import sba_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ext_req,
    input  logic [1:0]      dma_req,
    input  logic            cpu_req,
    input  logic [ID_W-1:0] dma_id0,
    input  logic [ID_W-1:0] dma_id1,
    input  logic [3:0]      cyc_run,
    input  logic [3:0]      cyc_done,
    input  logic [3:0]      cyc_last,
    input  logic [3:0]      cyc_lock,
    output logic [3:0]      grant,
    output logic [1:0]      grant_idx
);
    arb_st_t st_q, st_d;
    idx_t    win;
    logic    release_now, open_nx;
    logic    any_req;

    sba_pick #(.ID_W(ID_W)) u_pick (
        .ext_req(ext_req),
        .dma_req(dma_req),
        .id0    (dma_id0),
        .id1    (dma_id1),
        .win    (win)
    );

    sba_track u_track (
        .owner      (st_q.owner),
        .open_q     (st_q.open),
        .cyc_run    (cyc_run),
        .cyc_done   (cyc_done),
        .cyc_last   (cyc_last),
        .cyc_lock   (cyc_lock),
        .release_now(release_now),
        .open_d     (open_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.open = open_nx;
        if (release_now)
            st_d.owner = win;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.owner <= IDX_CPU;
            st_q.open  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NM; g++) begin : g_gnt
            assign grant[g] = (st_q.owner == idx_t'(g));
        end
    endgenerate
    assign grant_idx = st_q.owner;
    assign any_req   = ext_req || (|dma_req) || cpu_req;

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(grant) == 1);

    assert_hold_running_R6: assert property (@(posedge clk) disable iff (rst)
        (cyc_run[grant_idx] && !cyc_done[grant_idx]) |=> $stable(grant_idx));

    assert_lock_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (cyc_run[grant_idx] && cyc_done[grant_idx] && cyc_lock[grant_idx])
        |=> $stable(grant_idx));

    assert_ext_first_R3: assert property (@(posedge clk) disable iff (rst)
        (release_now && ext_req) |=> (grant_idx == IDX_EXT));

    assert_park_cpu_R5: assert property (@(posedge clk) disable iff (rst)
        (release_now && !any_req) |=> (grant_idx == IDX_CPU));
endmodule

// File: tb/sim_sba_top.sv
module sim_sba_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_req = 1'b0;
    logic [1:0] dma_req = 2'b00;
    logic       cpu_req = 1'b0;
    logic [2:0] dma_id0 = 3'd0;
    logic [2:0] dma_id1 = 3'd0;
    logic [3:0] cyc_run = 4'h0, cyc_done = 4'h0, cyc_last = 4'h0, cyc_lock = 4'h0;
    logic [3:0] grant;
    logic [1:0] grant_idx;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sba_top #(.ID_W(3)) u0 (
        .clk(clk), .rst(rst), .ext_req(ext_req), .dma_req(dma_req),
        .cpu_req(cpu_req), .dma_id0(dma_id0), .dma_id1(dma_id1),
        .cyc_run(cyc_run), .cyc_done(cyc_done), .cyc_last(cyc_last),
        .cyc_lock(cyc_lock), .grant(grant), .grant_idx(grant_idx)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_owner(input int exp, input string req);
        checks++;
        if (grant_idx !== 2'(exp) || grant !== (4'b1 << exp)) begin
            errors++;
            $display("FAIL %s: grant_idx=%0d grant=%b expected idx=%0d grant=%b",
                     req, grant_idx, grant, exp, 4'b1 << exp);
        end
    endtask

    task automatic clear_flags();
        cyc_run = 4'h0; cyc_done = 4'h0; cyc_last = 4'h0; cyc_lock = 4'h0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ext_req = 1'b0; dma_req = 2'b00; cpu_req = 1'b0;
        dma_id0 = 3'd0; dma_id1 = 3'd0;
        clear_flags();
        step(); step();
        rst = 1'b0;
    endtask

    // one single-clock bus cycle by master m
    task automatic beat(input int m, input bit last, input bit lock);
        clear_flags();
        cyc_run[m] = 1'b1; cyc_done[m] = 1'b1;
        cyc_last[m] = last; cyc_lock[m] = lock;
        step();
        clear_flags();
    endtask

    task automatic t_reset();
        do_reset();
        expect_owner(3, "R1 reset parks on CPU");
    endtask

    task automatic t_priority();
        do_reset();
        dma_id0 = 3'd1; dma_id1 = 3'd0;
        ext_req = 1; dma_req = 2'b11; cpu_req = 1;
        step();
        expect_owner(0, "R3 external beats all");
        ext_req = 0;
        step();
        expect_owner(1, "R4 DMA after external drops");
        dma_req = 2'b00;
        step();
        expect_owner(3, "R5 CPU after DMA drops");
    endtask

    task automatic t_dma_ids();
        do_reset();
        dma_id0 = 3'd2; dma_id1 = 3'd5; dma_req = 2'b11;
        step();
        expect_owner(2, "R4 larger ID channel 1");
        do_reset();
        dma_id0 = 3'd6; dma_id1 = 3'd1; dma_req = 2'b11;
        step();
        expect_owner(1, "R4 larger ID channel 0");
        do_reset();
        dma_id0 = 3'd4; dma_id1 = 3'd4; dma_req = 2'b11;
        step();
        expect_owner(1, "R4 equal IDs channel 0");
    endtask

    task automatic t_long_word();
        do_reset();
        cpu_req = 1; ext_req = 1;
        // the first piece starts in the same clock as the request
        beat(3, 0, 0);
        expect_owner(3, "R7 after piece 1");
        beat(3, 0, 0);
        expect_owner(3, "R7 after piece 2");
        step();
        expect_owner(3, "R7 idle gap inside operand");
        beat(3, 0, 0);
        expect_owner(3, "R7 after piece 3");
        beat(3, 1, 0);
        expect_owner(0, "R9 after piece 4");
    endtask

    task automatic t_long_cycle_and_ignore();
        do_reset();
        cpu_req = 1; ext_req = 1;
        cyc_run[3] = 1;
        cyc_run[1] = 1; cyc_done[1] = 1; cyc_last[1] = 1;
        step();
        expect_owner(3, "R6 running cycle holds");
        expect_owner(3, "R11 non-owner flags ignored");
        step();
        expect_owner(3, "R6 running cycle second clock");
        cyc_done[3] = 1; cyc_last[3] = 1;
        step();
        clear_flags();
        expect_owner(0, "R9 switch after long cycle");
    endtask

    task automatic t_rmw();
        do_reset();
        cpu_req = 1; dma_req = 2'b01;
        beat(3, 1, 1);
        expect_owner(3, "R8 locked read keeps bus");
        step();
        expect_owner(3, "R8 gap inside lock");
        beat(3, 1, 0);
        expect_owner(1, "R8 unlocked write releases");
    endtask

    task automatic t_dual_address();
        do_reset();
        dma_req = 2'b01;
        step();
        expect_owner(1, "R10 DMA takes idle CPU bus");
        ext_req = 1;
        beat(1, 1, 0);
        expect_owner(0, "R9 split between read and write operands");
        ext_req = 0;
        beat(0, 1, 0);
        expect_owner(1, "R9 DMA resumes for its write");
    endtask

    task automatic t_park_and_stay();
        do_reset();
        ext_req = 1;
        step();
        expect_owner(0, "R10 external preempts idle CPU");
        dma_req = 2'b10;
        step();
        expect_owner(0, "R3 external keeps bus over DMA");
        ext_req = 0; dma_req = 2'b00;
        step();
        expect_owner(3, "R5 park on CPU with no requests");
    endtask

    initial begin
        t_reset();
        t_priority();
        t_dma_ids();
        t_long_word();
        t_long_cycle_and_ignore();
        t_rmw();
        t_dual_address();
        t_park_and_stay();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule